// File: doc/BRIEF.md
# Eight-Event Capture with Priority Clear

This block keeps a record of events. Each of its event inputs is level-sensitive. While an input is high on a clock edge, the matching output bit latches high. The bit stays high after the input falls, until software or logic clears it. A synchronous set-all input marks every event pending at once. The asynchronous reset empties the record at any moment.

A clear-one strobe clears events one at a time. Every rising edge on the strobe removes the single pending event with the highest priority. The most significant bit has the highest priority. The clear wins in the cycle it is applied, even when that event's input is still high. If the input is still high, the event is captured again on the following clock. A consumer can therefore walk the pending events in priority order with repeated strobes, and a condition that persists is never lost. Edge detection on the event inputs is not built in. A pulse-shaping stage in front of the block provides it where it is wanted.

Top module: `evt_capture`

## Requirements
- R1: On a rising clock edge, every event input that is high sets its output bit. The bit then stays high after the input returns low, until a clear, set-all or reset changes it.
- R2: While rst is high, all output bits are low at once, without waiting for a clock. rst overrides setAll.
- R3: With rst low, setAll high on a clock edge drives every output bit high. setAll overrides both capture and clear-one.
- R4: A rising edge on clrOne is seen by comparing clrOne with its value at the previous clock edge. The register holding that value reads 0 after reset. On the edge where the rise is seen, exactly one bit is cleared: the highest-indexed output bit that is high. Bit NUM_EVENTS-1 has the highest priority and bit 0 the lowest.
- R5: The clear takes effect in its own cycle even if that event's input is high. If the input is still high at the next clock edge, the bit is set again there. Other inputs keep being captured during the clearing cycle.
- R6: Holding clrOne high for several cycles clears only one event, on the first edge.
- R7: A rising edge on clrOne while no output bit is high changes nothing. Inputs that are high on that edge are still captured.
- R8: An event input that is high when rst is released sets its bit on the first clock edge after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Asynchronous reset, active high; empties the record |
| setAll | input | 1 | Synchronous set-all, active high |
| evtIn | input | NUM_EVENTS | Level-sensitive event inputs |
| clrOne | input | 1 | Clear-one strobe; each rising edge removes the top pending event |
| evtOut | output | NUM_EVENTS | Pending event flags, bit NUM_EVENTS-1 highest priority |

## Verification
The bench builds the block with the default NUM_EVENTS of 8. At this width a random walk of inputs reaches every priority position, including the top and bottom bits. It also reaches clears taken while several events are pending, and clears taken while the top event's input is held high. Random toggling of clrOne produces held levels, single-cycle pulses and back-to-back edges. Rare set-all and mid-cycle resets land on top of pending clears and live inputs, which exercises the priority among reset, set-all and clear.

// File: rtl/evt_capture_pkg.sv
package evt_capture_pkg;
  // Per-cycle commands from the control to the event register
  typedef struct packed {
    logic setAll;    // force every event pending
    logic clearTop;  // remove the highest-priority pending event
  } evtStrobes_t;
endpackage

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_capture_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        setAll,
  input  logic        clrOne,
  output evtStrobes_t strobes
);
  logic clrPrev;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) clrPrev <= 1'b0;
    else     clrPrev <= clrOne;
  end

  always_comb begin
    strobes.setAll   = setAll;
    strobes.clearTop = clrOne & ~clrPrev;
  end

  // A clear strobe needs clrOne to have been low at the previous edge
  assert_clear_is_edge_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && strobes.clearTop) |-> !$past(clrOne));

  // A low-to-high step on clrOne must raise the clear strobe
  assert_edge_gives_clear_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && clrOne && !$past(clrOne)) |-> strobes.clearTop);
endmodule

// File: rtl/evt_datapath.sv
module evt_datapath
  import evt_capture_pkg::*;
#(
  parameter int NUM_EVENTS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_EVENTS-1:0] evtIn,
  input  evtStrobes_t           strobes,
  output logic [NUM_EVENTS-1:0] evtOut
);
  localparam int TOP = NUM_EVENTS - 1;

  logic [NUM_EVENTS-1:0] evtReg;
  logic [NUM_EVENTS-1:0] topMask;
  logic [NUM_EVENTS-1:0] evtNext;

  // One-hot mask of the highest pending bit
  for (genvar i = 0; i < NUM_EVENTS; i++) begin : g_prio
    if (i == TOP) begin : g_top
      assign topMask[i] = evtReg[i];
    end else begin : g_lower
      assign topMask[i] = evtReg[i] & ~(|evtReg[TOP:i+1]);
    end
  end

  always_comb begin
    if (strobes.setAll)
      evtNext = '1;
    else if (strobes.clearTop)
      evtNext = (evtReg | evtIn) & ~topMask;
    else
      evtNext = evtReg | evtIn;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) evtReg <= '0;
    else     evtReg <= evtNext;
  end

  assign evtOut = evtReg;

  // Set-all leaves every flag high
  assert_set_all_high_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && strobes.setAll) |-> (&evtReg));

  // No flag falls without a clear strobe
  assert_sticky_flags_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !strobes.setAll && !strobes.clearTop) |-> (($past(evtReg) & ~evtReg) == '0));

  // At most one flag falls per clear, and it is the highest one that was set
  assert_single_top_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !strobes.setAll) |->
      (($past(evtReg) & ~evtReg) == '0) ||
      ($onehot($past(evtReg) & ~evtReg) &&
       (($past(evtReg) & ~evtReg) > ($past(evtReg) & evtReg))));

  // A clear with something pending always removes one flag
  assert_clear_takes_effect_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !strobes.setAll && strobes.clearTop && (|evtReg)) |->
      $countones($past(evtReg) & ~evtReg) == 1);

  // A high input is missing afterwards only for the one cleared bit
  assert_capture_inputs_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $countones($past(evtIn) & ~evtReg) <= 1);
endmodule

// File: rtl/evt_capture.sv
module evt_capture
  import evt_capture_pkg::*;
#(
  parameter int NUM_EVENTS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  setAll,
  input  logic [NUM_EVENTS-1:0] evtIn,
  input  logic                  clrOne,
  output logic [NUM_EVENTS-1:0] evtOut
);
  evtStrobes_t strobes;

  evt_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .setAll  (setAll),
    .clrOne  (clrOne),
    .strobes (strobes)
  );

  evt_datapath #(.NUM_EVENTS(NUM_EVENTS)) u_data (
    .clk     (clk),
    .rst     (rst),
    .evtIn   (evtIn),
    .strobes (strobes),
    .evtOut  (evtOut)
  );
endmodule

// File: tb/tb_evt_capture.sv
`timescale 1ns/1ps
module tb_evt_capture;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         setAll = 1'b0;
  logic [N-1:0] evtIn = '0;
  logic         clrOne = 1'b0;
  logic [N-1:0] evtOut;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] expState = '0;
  logic         expPrev = 1'b0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  evt_capture #(.NUM_EVENTS(N)) dut (
    .clk(clk), .rst(rst), .setAll(setAll),
    .evtIn(evtIn), .clrOne(clrOne), .evtOut(evtOut)
  );

  function automatic logic [N-1:0] topOf(input logic [N-1:0] v);
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) return (N'(1) << i);
    return '0;
  endfunction

  function automatic logic [N-1:0] modelNext(input logic [N-1:0] cur, input logic [N-1:0] din,
                                             input logic set, input logic clrEdge);
    if (set) return '1;
    if (clrEdge) return (cur | din) & ~topOf(cur);
    return cur | din;
  endfunction

  task automatic check(input string req, input logic [N-1:0] expv);
    checks++;
    if (evtOut !== expv) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, evtOut, expv);
    end
  endtask

  // inputs already stable; advance one edge, update model, sample 1 ns later
  task automatic step(input string req);
    @(posedge clk);
    if (rst) begin
      expState = '0; expPrev = 1'b0;
    end else begin
      expState = modelNext(expState, evtIn, setAll, clrOne & ~expPrev);
      expPrev  = clrOne;
    end
    #1;
    check(req, expState);
  endtask

  task automatic drive(input logic s, input logic [N-1:0] d, input logic c);
    @(negedge clk);
    setAll = s; evtIn = d; clrOne = c;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1; check("R2 reset state", '0);

    // R8: input high at reset release captured on first edge
    @(negedge clk); evtIn = 8'h21; rst = 1'b0;
    step("R8 capture after release");
    // R1: sticky after input drops
    drive(0, 8'h00, 0); step("R1 sticky");
    drive(0, 8'h04, 0); step("R1 capture second");
    drive(0, 8'h00, 0); step("R1 hold");
    // R4: clear removes top pending bit (bit5)
    drive(0, 8'h00, 1); step("R4 clear top");
    // R6: held clrOne clears nothing more
    drive(0, 8'h00, 1); step("R6 held clear");
    drive(0, 8'h00, 1); step("R6 held clear again");
    // R5: clear while top input high, recapture next edge; other input captured
    drive(0, 8'h00, 0); step("R5 prep");
    drive(0, 8'h82, 0); step("R5 capture");
    drive(0, 8'h82, 1); step("R5 clear wins");
    if (evtOut[7] !== 1'b0) begin errors++; $display("FAIL R5 bit7 actual=%b expected=0", evtOut[7]); end
    checks++;
    drive(0, 8'h80, 0); step("R5 recapture");
    // R3: set-all overrides clear and capture
    drive(1, 8'h00, 1); step("R3 set all");
    drive(0, 8'h00, 0); step("R3 hold");
    // R2: async reset while set high, checked mid-cycle
    @(negedge clk); setAll = 1'b1; rst = 1'b1;
    #1; check("R2 async clear", '0);
    expState = '0; expPrev = 1'b0;
    step("R2 reset over set");
    @(negedge clk); rst = 1'b0; setAll = 1'b0; evtIn = '0; clrOne = 1'b0;
    step("R7 idle");
    // R7: clear with nothing pending, with an input high on that edge
    drive(0, 8'h00, 1); step("R7 empty clear");
    drive(0, 8'h00, 0); step("R7 low");
    drive(0, 8'h10, 1); step("R7 clear on empty with capture");
    // R4: walk several clears in priority order
    drive(0, 8'h4B, 0); step("R4 fill");
    for (int k = 0; k < 5; k++) begin
      drive(0, 8'h00, 1); step("R4 walk clear");
      drive(0, 8'h00, 0); step("R4 walk gap");
    end

    // random phase
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (($urandom % 200) == 0) begin
        rst = 1'b1; #1; check("R2 random async", '0);
      end else rst = 1'b0;
      setAll = (($urandom % 40) == 0);
      evtIn  = (($urandom % 3) == 0) ? N'($urandom) & N'($urandom) : '0;
      clrOne = $urandom % 2;
      step("R1 R4 R5 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule